// File: doc/BRIEF.md
# Countdown Watchdog with Selectable Expiry Action

This block is a watchdog peripheral reached over a simple 32-bit register bus. It has two registers. One holds the action to take on expiry and a read-only cause flag. The other holds the remaining tick count. Software arms the watchdog by choosing an action and loading a tick count. It keeps the system alive by rewriting the count before it runs out. If software stops rewriting, the count falls to zero. The block then raises an interrupt level, a non-maskable interrupt level or a fixed-length chip reset request, depending on the chosen action.

The cause flag records that the watchdog requested a chip reset. It is held by a flop that only the power-on reset input clears. After a reset caused by the watchdog, boot software can therefore still see why the system restarted. Register reads are combinational from the stored state. A read placed right after a write returns the new value, which lets software flush posted writes.

Top module: `wdt_guard`

## Requirements
- R1: After `rst_n` and `por_n` are released, the control register reads 0, the timer register reads 0, and `irq_o`, `nmi_o` and `chip_rst_o` are low.
- R2: The control register is at byte offset 0x00 and the timer register at 0x04. The action field is control bits [1:0], encoded 0 = none, 1 = interrupt, 2 = non-maskable interrupt, 3 = chip reset. Other control bits read 0 and ignore writes. Reads from any other offset return 0, and writes to any other offset change nothing.
- R3: A write to the timer register loads the written count at that clock edge. A read of the timer register returns the remaining count, so a read right after a write returns the written value.
- R4: The count decrements by one per clock while the action field is non-zero and the count is non-zero. While the action field is 0, the count holds.
- R5: Once the count has reached zero it stays at zero until the timer is written, and no further action fires.
- R6: With action 1, `irq_o` rises in the same cycle the count becomes zero by decrement. It stays high until the next timer write.
- R7: With action 2, `nmi_o` rises in the same cycle the count becomes zero by decrement. It stays high until the next timer write.
- R8: With action 3, `chip_rst_o` rises in the same cycle the count becomes zero by decrement. It stays high for exactly 16 clock cycles.
- R9: Control bit 31 reads 1 once a chip-reset expiry has occurred. Writes do not change it, `rst_n` does not clear it, and only `por_n` clears it.
- R10: Rewriting the timer before the count reaches zero prevents any expiry action.
- R11: Loading a count of 0 while an action is selected fires no action, because expiry needs a decrement from 1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| por_n | input | 1 | Asynchronous active-low power-on reset; only this clears the cause flag |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq_o | output | 1 | Interrupt level on expiry with action 1 |
| nmi_o | output | 1 | Non-maskable interrupt level on expiry with action 2 |
| chip_rst_o | output | 1 | 16-cycle chip reset request on expiry with action 3 |

## Verification
A miscounting counter shows on the timer read port within one cycle. It also shows as an expiry output that rises one or more cycles early or late against a count predicted from the write cycle. Wrong action decode shows in the expiry cycle itself, as the wrong one of the three outputs. Wrong clearing logic shows as a level that survives a reload, or as a cause flag that vanishes after `rst_n`; both are visible on the next read. A pulse-length fault shows as a high count other than 16 over a 20-cycle window.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_IRQ  = 2'd1,
        ACT_NMI  = 2'd2,
        ACT_CHIP = 2'd3
    } wdt_act_e;

    localparam int unsigned CTRL_WORD  = 0;
    localparam int unsigned TIMER_WORD = 1;

endpackage

// File: rtl/wdt_bus_decode.sv
module wdt_bus_decode #(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              wr_ctrl,
    output logic              wr_timer,
    output logic              rd_ctrl,
    output logic              rd_timer
);
    import wdt_guard_pkg::*;

    localparam int unsigned IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] word_idx;
    logic             aligned;
    logic             hit_ctrl;
    logic             hit_timer;

    always_comb begin
        word_idx  = bus_addr[ADDR_W-1:2];
        aligned   = (bus_addr[1:0] == 2'b00);
        hit_ctrl  = aligned && (word_idx == IDX_W'(CTRL_WORD));
        hit_timer = aligned && (word_idx == IDX_W'(TIMER_WORD));
        wr_ctrl   = bus_sel &&  bus_wr && hit_ctrl;
        wr_timer  = bus_sel &&  bus_wr && hit_timer;
        rd_ctrl   = bus_sel && !bus_wr && hit_ctrl;
        rd_timer  = bus_sel && !bus_wr && hit_timer;
    end

endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic [CNT_W-1:0] count_o,
    output logic             expire_o
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_state_t;

    cnt_state_t cnt_d, cnt_q;

    always_comb begin
        cnt_d    = cnt_q;
        expire_o = 1'b0;
        if (load) begin
            cnt_d.count = load_val;
        end else if (run && (cnt_q.count != '0)) begin
            cnt_d.count = cnt_q.count - CNT_W'(1);
            expire_o    = (cnt_q.count == CNT_W'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q.count;

endmodule

// File: rtl/wdt_action_gen.sv
module wdt_action_gen #(
    parameter int unsigned PULSE_LEN = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fire,
    input  wdt_guard_pkg::wdt_act_e  act,
    input  logic                     reload,
    output logic                     irq_o,
    output logic                     nmi_o,
    output logic                     chip_rst_o,
    output logic                     chip_req_o
);
    import wdt_guard_pkg::*;

    localparam int unsigned PW = $clog2(PULSE_LEN + 1);

    typedef struct packed {
        logic          irq;
        logic          nmi;
        logic [PW-1:0] pcnt;
    } act_state_t;

    act_state_t act_d, act_q;

    always_comb begin
        act_d      = act_q;
        chip_req_o = 1'b0;
        if (reload) begin
            act_d.irq = 1'b0;
            act_d.nmi = 1'b0;
        end
        if (act_q.pcnt != '0) act_d.pcnt = act_q.pcnt - PW'(1);
        if (fire) begin
            unique case (act)
                ACT_IRQ:  act_d.irq = 1'b1;
                ACT_NMI:  act_d.nmi = 1'b1;
                ACT_CHIP: begin
                    act_d.pcnt = PW'(PULSE_LEN);
                    chip_req_o = 1'b1;
                end
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_q <= '0;
        else        act_q <= act_d;
    end

    assign irq_o      = act_q.irq;
    assign nmi_o      = act_q.nmi;
    assign chip_rst_o = (act_q.pcnt != '0);

endmodule

// File: rtl/wdt_cause_flag.sv
module wdt_cause_flag (
    input  logic clk,
    input  logic por_n,
    input  logic set,
    output logic flag_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q | set;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard #(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned CNT_W     = 32,
    parameter int unsigned PULSE_LEN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              nmi_o,
    output logic              chip_rst_o
);
    import wdt_guard_pkg::*;

    typedef struct packed {
        wdt_act_e act;
    } ctrl_state_t;

    ctrl_state_t ctrl_d, ctrl_q;

    logic             wr_ctrl;
    logic             wr_timer;
    logic             rd_ctrl;
    logic             rd_timer;
    logic [CNT_W-1:0] cnt_val;
    logic             expire;
    logic             chip_req;
    logic             cause_flag;

    wdt_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .wr_ctrl  (wr_ctrl),
        .wr_timer (wr_timer),
        .rd_ctrl  (rd_ctrl),
        .rd_timer (rd_timer)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_ctrl) ctrl_d.act = wdt_act_e'(bus_wdata[1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '{act: ACT_NONE};
        else        ctrl_q <= ctrl_d;
    end

    wdt_countdown #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_timer),
        .load_val (bus_wdata[CNT_W-1:0]),
        .run      (ctrl_q.act != ACT_NONE),
        .count_o  (cnt_val),
        .expire_o (expire)
    );

    wdt_action_gen #(.PULSE_LEN(PULSE_LEN)) u_act (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (expire),
        .act        (ctrl_q.act),
        .reload     (wr_timer),
        .irq_o      (irq_o),
        .nmi_o      (nmi_o),
        .chip_rst_o (chip_rst_o),
        .chip_req_o (chip_req)
    );

    wdt_cause_flag u_flag (
        .clk    (clk),
        .por_n  (por_n),
        .set    (chip_req),
        .flag_o (cause_flag)
    );

    always_comb begin
        bus_rdata = '0;
        if (rd_ctrl) begin
            bus_rdata[1:0]        = ctrl_q.act;
            bus_rdata[DATA_W-1]   = cause_flag;
        end else if (rd_timer) begin
            bus_rdata[CNT_W-1:0]  = cnt_val;
        end
    end

endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              por_n,
    input logic              wr_ctrl,
    input logic              wr_timer,
    input logic [DATA_W-1:0] wdata,
    input logic [1:0]        act,
    input logic [CNT_W-1:0]  count,
    input logic              irq,
    input logic              nmi,
    input logic              chip_rst,
    input logic              flag
);
    AST_CTRL_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> act == $past(wdata[1:0])); // R2
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_timer |=> count == $past(wdata[CNT_W-1:0])); // R3
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (act != 2'd0 && count != '0 && !wr_timer) |=> count == $past(count) - CNT_W'(1)); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (act == 2'd0 && !wr_timer) |=> $stable(count)); // R4
    AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && !wr_timer) |=> count == '0); // R5
    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_timer) |=> irq); // R6
    AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> count == '0); // R6
    AST_NMI_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi && !wr_timer) |=> nmi); // R7
    AST_ONE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq, nmi})); // R7
    AST_CAUSE_SET: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        chip_rst |-> flag); // R9
endmodule

bind wdt_guard wdt_guard_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .por_n    (por_n),
    .wr_ctrl  (wr_ctrl),
    .wr_timer (wr_timer),
    .wdata    (bus_wdata),
    .act      (ctrl_q.act),
    .count    (cnt_val),
    .irq      (irq_o),
    .nmi      (nmi_o),
    .chip_rst (chip_rst_o),
    .flag     (cause_flag)
);

// File: tb/wdt_guard_test.sv
`timescale 1ns/1ps
module wdt_guard_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        por_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, nmi_o, chip_rst_o;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    wdt_guard uut (
        .clk(clk), .rst_n(rst_n), .por_n(por_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .nmi_o(nmi_o), .chip_rst_o(chip_rst_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // caller stands at a negedge; one posedge is crossed
    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic quiesce();
        bus_write(4'h4, 32'h0);
        bus_write(4'h0, 32'h0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        bus_read(4'h0, d); check("R1 ctrl", d, 32'h0);
        bus_read(4'h4, d); check("R1 timer", d, 32'h0);
        check("R1 outs", {29'h0, irq_o, nmi_o, chip_rst_o}, 32'h0);
    endtask

    task automatic t_map();
        logic [31:0] d;
        bus_write(4'h4, 32'h1234_5678);
        bus_read(4'h4, d); check("R3 readback", d, 32'h1234_5678);
        bus_write(4'h0, 32'hFFFF_FFFC);
        bus_read(4'h0, d); check("R2/R9 ctrl reserved bits", d, 32'h0);
        bus_write(4'h8, 32'hDEAD_BEEF);
        bus_read(4'h8, d); check("R2 unmapped read", d, 32'h0);
        bus_read(4'h0, d); check("R2 ctrl untouched", d, 32'h0);
        idle(4);
        bus_read(4'h4, d); check("R4 hold with action 0", d, 32'h1234_5678);
        bus_write(4'h0, 32'h7FFF_FFFE);
        bus_read(4'h0, d); check("R2 action field", d, 32'h2);
        quiesce();
    endtask

    task automatic t_irq();
        logic [31:0] d;
        quiesce();
        bus_write(4'h0, 32'h1);
        bus_write(4'h4, 32'd10);
        bus_read(4'h4, d); check("R3 load", d, 32'd10);
        idle(9);
        bus_read(4'h4, d); check("R4 countdown", d, 32'd1);
        check("R6 irq before zero", {31'h0, irq_o}, 32'h0);
        idle(1);
        check("R6 irq at zero", {31'h0, irq_o}, 32'h1);
        check("R6 others quiet", {30'h0, nmi_o, chip_rst_o}, 32'h0);
        idle(5);
        check("R6 irq held", {31'h0, irq_o}, 32'h1);
        bus_read(4'h4, d); check("R5 zero held", d, 32'h0);
        bus_write(4'h4, 32'h0);
        check("R6 irq cleared by reload", {31'h0, irq_o}, 32'h0);
        idle(3);
        check("R11 zero load no fire", {29'h0, irq_o, nmi_o, chip_rst_o}, 32'h0);
    endtask

    task automatic t_nmi();
        quiesce();
        bus_write(4'h0, 32'h2);
        bus_write(4'h4, 32'd6);
        idle(5);
        check("R7 nmi before zero", {31'h0, nmi_o}, 32'h0);
        idle(1);
        check("R7 nmi at zero", {31'h0, nmi_o}, 32'h1);
        check("R7 irq quiet", {31'h0, irq_o}, 32'h0);
        idle(3);
        check("R7 nmi held", {31'h0, nmi_o}, 32'h1);
        bus_write(4'h4, 32'h0);
        check("R7 nmi cleared", {31'h0, nmi_o}, 32'h0);
    endtask

    task automatic t_keepalive();
        logic [31:0] d;
        int          seen = 0;
        quiesce();
        bus_write(4'h0, 32'h1);
        bus_write(4'h4, 32'd8);
        for (int i = 0; i < 6; i++) begin
            idle(5);
            if (irq_o) seen++;
            bus_write(4'h4, 32'd8);
        end
        check("R10 no expiry with keep-alive", seen, 0);
        bus_write(4'h0, 32'h0);
        bus_read(4'h4, d); check("R4 count at disable", d, 32'd7);
        idle(10);
        bus_read(4'h4, d); check("R4 hold after disable", d, 32'd7);
    endtask

    task automatic t_chip();
        logic [31:0] d;
        int          hi = 0;
        quiesce();
        bus_write(4'h0, 32'h3);
        bus_write(4'h4, 32'd4);
        idle(3);
        check("R8 no pulse yet", {31'h0, chip_rst_o}, 32'h0);
        bus_read(4'h0, d); check("R9 flag clear before", d, 32'h3);
        idle(1);
        check("R8 pulse starts", {31'h0, chip_rst_o}, 32'h1);
        bus_read(4'h0, d); check("R9 flag set", d, 32'h8000_0003);
        for (int i = 0; i < 20; i++) begin
            if (chip_rst_o) hi++;
            @(negedge clk);
        end
        check("R8 pulse length", hi, 16);
        rst_n = 1'b0; idle(2); rst_n = 1'b1;
        bus_read(4'h0, d); check("R9 flag survives rst_n", d, 32'h8000_0000);
        bus_write(4'h0, 32'h0);
        bus_read(4'h0, d); check("R9 flag ignores write", d, 32'h8000_0000);
        por_n = 1'b0; idle(2); por_n = 1'b1;
        bus_read(4'h0, d); check("R9 flag cleared by por_n", d, 32'h0);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1; por_n = 1'b1;
        idle(1);
        t_reset();
        t_map();
        t_irq();
        t_nmi();
        t_keepalive();
        t_chip();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule